// File: doc/BRIEF.md
# Fault Confinement Error Counters

This block keeps the error bookkeeping for a CAN FD protocol controller. It has two 9-bit confinement counters, one for transmit and one for receive. Single-cycle strobes from the protocol engine move them up by one or by eight, or down by one. Each strobe goes to only one of the two counters, chosen by whether the node is transmitting or receiving in that cycle. The block also keeps two 16-bit statistics counters. They count error events separately for the nominal bit-rate phase and for the data bit-rate phase, and the current sample-point type picks which one counts.

From the two confinement counters and two software-programmed limits, the block works out the node's state: error active, error passive or bus-off. It also raises a warning flag and gives a one-cycle pulse each time the node enters or leaves error passive. A software preset port can load any subset of the four counters with one value. A preset wins over any strobe aimed at the same counter in the same cycle. Error detection, error frames and the bus-off recovery sequence belong to other blocks.

Top module: `err_confine_ctr`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows all four counters at zero, `state_o` at 0 (error active), and `warn_o` and `passive_chg_o` low.
- R2: A strobe changes only `tx_cnt_o` while `role_tx_i` is 1, and only `rx_cnt_o` while `role_tx_i` is 0. The other confinement counter holds its value.
- R3: The strobes `add_one_i`, `add_eight_i` and `sub_one_i` change the selected confinement counter by +1, +8 or -1, visible one clock after the strobe. Subtracting one from zero leaves zero, and an add that would pass 511 stops at 511.
- R4: `preset_sel_i` bit 0 selects the transmit counter, bit 1 the receive counter, bit 2 the nominal-phase counter and bit 3 the data-phase counter. Every selected counter loads `preset_val_i` (zero-extended) one clock later. A selected counter ignores any strobe in the same cycle.
- R5: On `add_one_i` or `add_eight_i`, one statistics counter goes up by exactly one, whatever the role. With `sample_kind_i` = 0 it is the nominal-phase counter; with 1 (data) or 2 (secondary) it is the data-phase counter; with 3 neither counts. `sub_one_i` never lowers either of them.
- R6: `state_o` is 2 (bus-off) whenever either confinement counter is above 255.
- R7: If neither counter is above 255, `state_o` is 1 (error passive) when either counter is strictly above `passive_lim_i`, and 0 (error active) otherwise.
- R8: `warn_o` is high exactly while either confinement counter is greater than or equal to `warn_lim_i`.
- R9: `passive_chg_o` is high for one cycle, in the first cycle `state_o` shows a change into or out of error passive, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| add_one_i | input | 1 | Strobe: add one to the role counter |
| add_eight_i | input | 1 | Strobe: add eight to the role counter |
| sub_one_i | input | 1 | Strobe: subtract one from the role counter |
| role_tx_i | input | 1 | 1 = node transmitting, 0 = node receiving |
| sample_kind_i | input | 2 | 0 nominal, 1 data, 2 secondary, 3 none |
| preset_sel_i | input | 4 | Preset targets: tx, rx, nominal, data (bits 0 to 3) |
| preset_val_i | input | 9 | Preset value |
| passive_lim_i | input | 8 | Error-passive limit (software usually writes 127) |
| warn_lim_i | input | 8 | Warning limit (software usually writes 63) |
| tx_cnt_o | output | 9 | Transmit error counter |
| rx_cnt_o | output | 9 | Receive error counter |
| nom_cnt_o | output | 16 | Nominal-phase error statistics |
| dat_cnt_o | output | 16 | Data-phase error statistics |
| state_o | output | 2 | 0 active, 1 passive, 2 bus-off |
| warn_o | output | 1 | Warning-limit flag |
| passive_chg_o | output | 1 | Pulse when entering or leaving error passive |

## Verification
The hard corners sit at the ends of the counter range: the floor at zero, the ceiling at 511, and the steps across 255 and across each limit. Strobes alone would need hundreds of cycles to reach them. The stimulus therefore presets both confinement counters to every value from 0 to 511, applies each strobe once in each role, and repeats the sweep under three limit settings. Every threshold crossing and every entry into or exit from error passive then happens from both directions. A separate pass drives all sixteen preset masks together with an add strobe, to check that the preset wins.

// File: rtl/errc_pkg.sv
// Shared encodings for the fault confinement counter block.
// Assumes: the state code and sample-kind codes below are what neighbours decode.
package errc_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_PASSIVE = 2'd1,
        ST_BUSOFF  = 2'd2
    } conf_state_e;

    localparam logic [1:0] SMP_NOMINAL = 2'd0;
    localparam logic [1:0] SMP_DATA    = 2'd1;
    localparam logic [1:0] SMP_SECOND  = 2'd2;

    // Preset select bit positions
    localparam int PS_TX  = 0;
    localparam int PS_RX  = 1;
    localparam int PS_NOM = 2;
    localparam int PS_DAT = 3;
    localparam int PS_W   = 4;

endpackage

// File: rtl/errc_role_ctr.sv
// Confinement counter for one role (transmit or receive).
// Applies +1, +8 or -1 when this role is selected. It saturates at all-ones
// and stops at zero. A load overrides any strobe in the same cycle.
// Assumes: strobes are mutually exclusive; if not, add-eight wins, then add-one.
module errc_role_ctr #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic             add_one_i,
    input  logic             add_eight_i,
    input  logic             sub_one_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W:0]   STEP_ONE   = (CNT_W+1)'(1);
    localparam logic [CNT_W:0]   STEP_EIGHT = (CNT_W+1)'(8);
    localparam logic [CNT_W-1:0] CNT_MAX    = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   sum;
    logic [CNT_W:0]   step;

    // Choose the add step from the active strobe
    always_comb begin
        step = add_eight_i ? STEP_EIGHT : STEP_ONE;
        sum  = {1'b0, cnt_q} + step;
    end

    // Next-value selection: load, add with ceiling, subtract with floor
    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (sel_i && (add_one_i || add_eight_i)) begin
            cnt_d = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
        end else if (sel_i && sub_one_i) begin
            cnt_d = (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);
        end
    end

    // Counter register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/errc_stat_ctr.sv
// Statistics counter for errors in one bit-rate phase.
// Goes up by one per bump and saturates at all-ones. A load of the narrower
// preset value is zero-extended and wins over a bump.
// Assumes: STAT_W >= VAL_W.
module errc_stat_ctr #(
    parameter int STAT_W = 16,
    parameter int VAL_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              bump_i,
    input  logic              load_i,
    input  logic [VAL_W-1:0]  load_val_i,
    output logic [STAT_W-1:0] cnt_o
);
    localparam logic [STAT_W-1:0] STAT_MAX = {STAT_W{1'b1}};

    logic [STAT_W-1:0] cnt_q, cnt_d;

    // Next-value selection: load, or saturating bump
    always_comb begin
        cnt_d = cnt_q;
        if (load_i)                                  cnt_d = STAT_W'(load_val_i);
        else if (sel_i && bump_i && cnt_q != STAT_MAX) cnt_d = cnt_q + STAT_W'(1);
    end

    // Counter register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/errc_state_eval.sv
// Works out the confinement state and warning flag from the two role counters
// and the limits, and pulses when the passive-or-not status changes.
// Assumes: CNT_W = LIM_W + 1, so bus-off means "above the largest limit value".
module errc_state_eval
    import errc_pkg::*;
#(
    parameter int CNT_W = 9,
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_cnt_i,
    input  logic [CNT_W-1:0] rx_cnt_i,
    input  logic [LIM_W-1:0] passive_lim_i,
    input  logic [LIM_W-1:0] warn_lim_i,
    output conf_state_e      state_o,
    output logic             warn_o,
    output logic             passive_chg_o
);
    localparam logic [CNT_W-1:0] BUSOFF_ABOVE = CNT_W'((1 << LIM_W) - 1);

    logic [CNT_W-1:0] plim, wlim;
    logic             is_passive, was_passive_q;

    // Classify the counters against the limits
    always_comb begin
        plim = CNT_W'(passive_lim_i);
        wlim = CNT_W'(warn_lim_i);
        if (tx_cnt_i > BUSOFF_ABOVE || rx_cnt_i > BUSOFF_ABOVE)
            state_o = ST_BUSOFF;
        else if (tx_cnt_i > plim || rx_cnt_i > plim)
            state_o = ST_PASSIVE;
        else
            state_o = ST_ACTIVE;
        warn_o     = (tx_cnt_i >= wlim) || (rx_cnt_i >= wlim);
        is_passive = (state_o == ST_PASSIVE);
    end

    // Remember last cycle's passive status for the change pulse
    always_ff @(posedge clk) begin
        if (!rst_n) was_passive_q <= 1'b0;
        else        was_passive_q <= is_passive;
    end

    assign passive_chg_o = is_passive ^ was_passive_q;
endmodule

// File: rtl/err_confine_ctr.sv
// Fault confinement counters: transmit/receive confinement counters routed by
// node role, per-phase error statistics, state evaluation and software preset.
// Assumes: strobes are single-cycle and mutually exclusive; limits are quasi-static.
module err_confine_ctr
    import errc_pkg::*;
#(
    parameter int CNT_W  = 9,
    parameter int STAT_W = 16,
    parameter int LIM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_one_i,
    input  logic              add_eight_i,
    input  logic              sub_one_i,
    input  logic              role_tx_i,
    input  logic [1:0]        sample_kind_i,
    input  logic [3:0]        preset_sel_i,
    input  logic [CNT_W-1:0]  preset_val_i,
    input  logic [LIM_W-1:0]  passive_lim_i,
    input  logic [LIM_W-1:0]  warn_lim_i,
    output logic [CNT_W-1:0]  tx_cnt_o,
    output logic [CNT_W-1:0]  rx_cnt_o,
    output logic [STAT_W-1:0] nom_cnt_o,
    output logic [STAT_W-1:0] dat_cnt_o,
    output logic [1:0]        state_o,
    output logic              warn_o,
    output logic              passive_chg_o
);
    localparam int N_ROLE  = 2;
    localparam int N_PHASE = 2;

    logic [CNT_W-1:0]  role_cnt  [N_ROLE];
    logic [STAT_W-1:0] phase_cnt [N_PHASE];
    logic [N_ROLE-1:0] role_sel;
    logic [N_PHASE-1:0] phase_sel;
    logic              bump;
    conf_state_e       st;

    // Decode role and phase selects for the counters
    always_comb begin
        role_sel[0]  = role_tx_i;
        role_sel[1]  = !role_tx_i;
        phase_sel[0] = (sample_kind_i == SMP_NOMINAL);
        phase_sel[1] = (sample_kind_i == SMP_DATA) || (sample_kind_i == SMP_SECOND);
        bump         = add_one_i || add_eight_i;
    end

    for (genvar i = 0; i < N_ROLE; i++) begin : g_role
        errc_role_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk         (clk),
            .rst_n       (rst_n),
            .sel_i       (role_sel[i]),
            .add_one_i   (add_one_i),
            .add_eight_i (add_eight_i),
            .sub_one_i   (sub_one_i),
            .load_i      (preset_sel_i[PS_TX + i]),
            .load_val_i  (preset_val_i),
            .cnt_o       (role_cnt[i])
        );
    end

    for (genvar j = 0; j < N_PHASE; j++) begin : g_phase
        errc_stat_ctr #(.STAT_W(STAT_W), .VAL_W(CNT_W)) u_stat (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel_i      (phase_sel[j]),
            .bump_i     (bump),
            .load_i     (preset_sel_i[PS_NOM + j]),
            .load_val_i (preset_val_i),
            .cnt_o      (phase_cnt[j])
        );
    end

    errc_state_eval #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_eval (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_cnt_i      (role_cnt[0]),
        .rx_cnt_i      (role_cnt[1]),
        .passive_lim_i (passive_lim_i),
        .warn_lim_i    (warn_lim_i),
        .state_o       (st),
        .warn_o        (warn_o),
        .passive_chg_o (passive_chg_o)
    );

    assign tx_cnt_o  = role_cnt[0];
    assign rx_cnt_o  = role_cnt[1];
    assign nom_cnt_o = phase_cnt[0];
    assign dat_cnt_o = phase_cnt[1];
    assign state_o   = st;
endmodule

// File: rtl/err_confine_ctr_chk.sv
// Property checker for err_confine_ctr, attached by bind below.
module err_confine_ctr_chk #(
    parameter int CNT_W  = 9,
    parameter int STAT_W = 16,
    parameter int LIM_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              add_one_i,
    input logic              add_eight_i,
    input logic              sub_one_i,
    input logic              role_tx_i,
    input logic [1:0]        sample_kind_i,
    input logic [3:0]        preset_sel_i,
    input logic [CNT_W-1:0]  preset_val_i,
    input logic [LIM_W-1:0]  passive_lim_i,
    input logic [LIM_W-1:0]  warn_lim_i,
    input logic [CNT_W-1:0]  tx_cnt_o,
    input logic [CNT_W-1:0]  rx_cnt_o,
    input logic [STAT_W-1:0] nom_cnt_o,
    input logic [STAT_W-1:0] dat_cnt_o,
    input logic [1:0]        state_o,
    input logic              warn_o,
    input logic              passive_chg_o
);
    localparam logic [CNT_W-1:0] TOP8 = CNT_W'((1 << LIM_W) - 1);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (tx_cnt_o == '0 && rx_cnt_o == '0 && nom_cnt_o == '0 &&
                    dat_cnt_o == '0 && state_o == 2'd0 && !passive_chg_o));

    a_r2_rx_held_when_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (role_tx_i && !preset_sel_i[1]) |=> $stable(rx_cnt_o));

    a_r2_tx_held_when_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (!role_tx_i && !preset_sel_i[0]) |=> $stable(tx_cnt_o));

    a_r3_floor_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (role_tx_i && sub_one_i && !add_one_i && !add_eight_i &&
         tx_cnt_o == '0 && !preset_sel_i[0]) |=> tx_cnt_o == '0);

    a_r4_preset_tx_loads: assert property (@(posedge clk) disable iff (!rst_n)
        preset_sel_i[0] |=> tx_cnt_o == $past(preset_val_i));

    a_r5_nominal_never_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !preset_sel_i[2] |=> nom_cnt_o >= $past(nom_cnt_o));

    a_r6_busoff_above_top: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt_o > TOP8 || rx_cnt_o > TOP8) |-> state_o == 2'd2);

    a_r9_pulse_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
        passive_chg_o |-> ((state_o == 2'd1) != ($past(state_o) == 2'd1)));
endmodule

bind err_confine_ctr err_confine_ctr_chk #(
    .CNT_W(CNT_W), .STAT_W(STAT_W), .LIM_W(LIM_W)
) u_chk (.*);

// File: tb/tb_err_confine_ctr.sv
`timescale 1ns/1ps
module tb_err_confine_ctr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        add_one_i = 0, add_eight_i = 0, sub_one_i = 0, role_tx_i = 0;
    logic [1:0]  sample_kind_i = 0;
    logic [3:0]  preset_sel_i = 0;
    logic [8:0]  preset_val_i = 0;
    logic [7:0]  passive_lim_i = 8'd127, warn_lim_i = 8'd63;
    logic [8:0]  tx_cnt_o, rx_cnt_o;
    logic [15:0] nom_cnt_o, dat_cnt_o;
    logic [1:0]  state_o;
    logic        warn_o, passive_chg_o;

    int n_chk = 0, n_bad = 0;
    int m_tx = 0, m_rx = 0, m_nom = 0, m_dat = 0;
    bit m_prev_pas = 0;

    always #2.5 clk = ~clk;

    err_confine_ctr dut (.*);

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic check_all(input string rq);
        int  est;
        bit  ewarn, epas;
        if (m_tx > 255 || m_rx > 255) est = 2;
        else if (m_tx > passive_lim_i || m_rx > passive_lim_i) est = 1;
        else est = 0;
        ewarn = (m_tx >= warn_lim_i) || (m_rx >= warn_lim_i);
        epas  = (est == 1);
        chk(tx_cnt_o == m_tx, rq, "tx", tx_cnt_o, m_tx);
        chk(rx_cnt_o == m_rx, rq, "rx", rx_cnt_o, m_rx);
        chk(nom_cnt_o == m_nom, "R5", "nominal", nom_cnt_o, m_nom);
        chk(dat_cnt_o == m_dat, "R5", "data", dat_cnt_o, m_dat);
        chk(state_o == est, (est == 2) ? "R6" : "R7", "state", state_o, est);
        chk(warn_o == ewarn, "R8", "warn", warn_o, ewarn);
        chk(passive_chg_o == (epas != m_prev_pas), "R9", "pulse",
            passive_chg_o, (epas != m_prev_pas));
        m_prev_pas = epas;
    endtask

    // op: 0 none, 1 add one, 2 add eight, 3 subtract one
    task automatic step(input int op, input bit role, input int smp,
                        input logic [3:0] sel, input int val, input string rq);
        int d;
        @(negedge clk);
        add_one_i = (op == 1); add_eight_i = (op == 2); sub_one_i = (op == 3);
        role_tx_i = role; sample_kind_i = smp[1:0];
        preset_sel_i = sel; preset_val_i = val[8:0];
        @(posedge clk);
        @(negedge clk);
        add_one_i = 0; add_eight_i = 0; sub_one_i = 0; preset_sel_i = 0;
        d = (op == 1) ? 1 : (op == 2) ? 8 : (op == 3) ? -1 : 0;
        if (sel[0]) m_tx = val;
        else if (role && d != 0) m_tx = (m_tx + d < 0) ? 0 : (m_tx + d > 511) ? 511 : m_tx + d;
        if (sel[1]) m_rx = val;
        else if (!role && d != 0) m_rx = (m_rx + d < 0) ? 0 : (m_rx + d > 511) ? 511 : m_rx + d;
        if (sel[2]) m_nom = val;
        else if (d > 0 && smp == 0) m_nom++;
        if (sel[3]) m_dat = val;
        else if (d > 0 && (smp == 1 || smp == 2)) m_dat++;
        check_all(rq);
    endtask

    initial begin
        #(150000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_all("R1");              // R1: reset state
        rst_n = 1'b1;

        // R2: role routing with fixed starting values
        step(0, 0, 3, 4'b0011, 20, "R4");
        step(1, 1, 0, 4'b0000, 0, "R2");
        step(3, 0, 1, 4'b0000, 0, "R2");
        step(2, 0, 2, 4'b0000, 0, "R2");
        step(2, 1, 3, 4'b0000, 0, "R2");

        // R3/R6/R7/R8/R9: every value under every strobe, role and limit set
        for (int cfg = 0; cfg < 3; cfg++) begin
            passive_lim_i = (cfg == 0) ? 8'd127 : (cfg == 1) ? 8'd10 : 8'd255;
            warn_lim_i    = (cfg == 0) ? 8'd63  : (cfg == 1) ? 8'd200 : 8'd0;
            for (int r = 0; r < 2; r++)
                for (int v = 0; v < 512; v++)
                    for (int op = 1; op < 4; op++) begin
                        step(0, r[0], 3, 4'b0011, v, "R4");
                        step(op, r[0], v % 4, 4'b0000, 0, "R3");
                    end
        end

        // R4: every preset mask together with a colliding add strobe
        passive_lim_i = 8'd127; warn_lim_i = 8'd63;
        for (int s = 0; s < 16; s++) begin
            step(2, s[0], s % 3, s[3:0], 100 + 9 * s, "R4");
            step(1, s[1], s % 3, s[3:0], 300 + s, "R4");
        end
        // R5: subtract never lowers statistics
        step(3, 1, 0, 4'b0000, 0, "R5");
        step(3, 0, 1, 4'b0000, 0, "R5");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule